// File: doc/BRIEF.md
# One-Hot AND-OR Crossbar Switch

This block is the data-path switch of a network-on-chip router. It has the same number of inputs and outputs. Every output has its own select field, supplied by external arbitration and routing logic, and the field names the input word that output carries. Each output is an N-to-1 selector built as a row of AND gates, one per input, each gated by a one-hot enable bit, followed by an OR reduction of the products. A per-input valid bit goes through the same AND-OR path next to the data.

A parameter picks the select format for all outputs. In the one-hot format the select vector is the enable vector. In the binary format each output gets an index, and a decoder turns it into enables. Each decoder term matches the index bits that must be one and the inverted bits that must be zero. Bad selects are flagged on each output: more than one bit set in one-hot format, or an index past the last port in binary format. A second parameter adds one output register stage with a synchronous active-low reset. Without it the switch is purely combinational. A switch shared by M lanes or virtual channels on each of N links is the same block with N×M ports, and any set of connections may be active at once.

Top module: `onehot_xbar`

## Requirements
- R1: In one-hot format, an output whose select has exactly one bit set carries that input's data word and valid bit. Bit i of output k's select field (bits [k*N +: N]) chooses input i.
- R2: An output whose enable vector is all zeros drives all-zero data, valid low and error low.
- R3: In one-hot format, an output whose select has two or more bits set raises its error bit. Its data is the bitwise OR of the selected input words and its valid is the OR of their valid bits.
- R4: In binary format, an output's index field (bits [k*W +: W], W = ceil(log2 N)) with value i < N routes input i to that output with error low.
- R5: In binary format, an index of N or more gives all-zero data and valid low on that output, and raises that output's error bit.
- R6: Several outputs may select the same input in the same cycle, and each receives an identical copy of the word.
- R7: An output's valid is the OR of the valid bits of its enabled inputs. Data passes whether or not those valid bits are set.
- R8: With the output register enabled, data, valid and error appear one clock edge after the inputs and selects change. An edge with reset low clears all three to zero.
- R9: With the output register disabled, the outputs follow the inputs and selects with no clock edge in between.
- R10: Each output's selection is independent of the others, so any permutation of inputs to outputs is carried in one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| in_data | input | N_PORTS*DATA_W | Input words, input i in bits [i*DATA_W +: DATA_W] |
| in_valid | input | N_PORTS | Valid bit per input |
| out_sel | input | N_PORTS*SEL_W | Per-output select, one-hot (SEL_W = N_PORTS) or binary index (SEL_W = ceil(log2 N_PORTS)) |
| out_data | output | N_PORTS*DATA_W | Output words, output k in bits [k*DATA_W +: DATA_W] |
| out_valid | output | N_PORTS | Valid bit per output |
| out_err | output | N_PORTS | Invalid-select flag per output |

## Verification
The out-of-range binary index can only happen when the port count is not a power of two. A second instance of the switch therefore uses five ports, binary select and the output register, so indices 5, 6 and 7 can be driven on some outputs while the other outputs still route normally. The valid bits and the data words are set independently in the stimulus. Some patterns send a word whose valid bit is low, and some OR together enabled inputs with mixed valid bits, so a valid that merely copies the data path would be caught.

// File: rtl/onehot_xbar_pkg.sv
package onehot_xbar_pkg;

    typedef enum logic {
        SEL_ONEHOT = 1'b0,
        SEL_BINARY = 1'b1
    } sel_fmt_e;

    function automatic int sel_width(input int n, input sel_fmt_e fmt);
        if (fmt == SEL_ONEHOT) begin
            return n;
        end
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/xbar_sel_decode.sv
module xbar_sel_decode
    import onehot_xbar_pkg::*;
#(
    parameter int       N_PORTS = 4,
    parameter sel_fmt_e SEL_FMT = SEL_ONEHOT,
    parameter int       SEL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   sel,
    output logic [N_PORTS-1:0] en,
    output logic               err
);

    generate
        if (SEL_FMT == SEL_ONEHOT) begin : g_onehot
            logic seen;
            logic multi;

            assign en = sel;

            always_comb begin
                seen  = 1'b0;
                multi = 1'b0;
                for (int i = 0; i < N_PORTS; i++) begin
                    if (sel[i]) begin
                        if (seen) begin
                            multi = 1'b1;
                        end
                        seen = 1'b1;
                    end
                end
            end

            assign err = multi;

            p_multi_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
                ($countones(sel) > 1) |-> err);
            p_single_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
                ($countones(sel) <= 1) |-> !err);
        end else begin : g_binary
            localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(N_PORTS - 1);

            for (genvar i = 0; i < N_PORTS; i++) begin : g_term
                localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
                logic term;
                always_comb begin
                    term = 1'b1;
                    for (int b = 0; b < SEL_W; b++) begin
                        term = term & (IDX[b] ? sel[b] : ~sel[b]);
                    end
                end
                assign en[i] = term;
            end

            assign err = ~|en;

            p_onehot_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(en));
            p_index_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (sel <= LAST_IDX) |-> (en[sel] && !err));
            p_out_of_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (sel > LAST_IDX) |-> ((en == '0) && err));
        end
    endgenerate

endmodule

// File: rtl/xbar_andor_mux.sv
module xbar_andor_mux #(
    parameter int N_PORTS = 4,
    parameter int DATA_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_PORTS*DATA_W-1:0] in_data,
    input  logic [N_PORTS-1:0]        in_valid,
    input  logic [N_PORTS-1:0]        en,
    output logic [DATA_W-1:0]         out_data,
    output logic                      out_valid
);

    logic [DATA_W-1:0]  prod_data [N_PORTS];
    logic [N_PORTS-1:0] prod_valid;

    generate
        for (genvar i = 0; i < N_PORTS; i++) begin : g_and_row
            assign prod_data[i]  = in_data[i*DATA_W +: DATA_W] & {DATA_W{en[i]}};
            assign prod_valid[i] = in_valid[i] & en[i];
        end
    endgenerate

    always_comb begin
        out_data = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            out_data = out_data | prod_data[i];
        end
    end

    assign out_valid = |prod_valid;

    p_zero_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> ((out_data == '0) && !out_valid));
    p_valid_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((en & in_valid) != '0) |-> out_valid);
    p_valid_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((en & in_valid) == '0) |-> !out_valid);

endmodule

// File: rtl/xbar_out_stage.sv
module xbar_out_stage #(
    parameter int WIDTH   = 8,
    parameter bit OUT_REG = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else begin
                    q <= d;
                end
            end

            p_one_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (q == $past(d)));
        end else begin : g_wire
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/onehot_xbar.sv
module onehot_xbar
    import onehot_xbar_pkg::*;
#(
    parameter int       N_PORTS = 4,
    parameter int       DATA_W  = 8,
    parameter sel_fmt_e SEL_FMT = SEL_ONEHOT,
    parameter bit       OUT_REG = 1'b0,
    localparam int      SEL_W   = sel_width(N_PORTS, SEL_FMT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_PORTS*DATA_W-1:0] in_data,
    input  logic [N_PORTS-1:0]        in_valid,
    input  logic [N_PORTS*SEL_W-1:0]  out_sel,
    output logic [N_PORTS*DATA_W-1:0] out_data,
    output logic [N_PORTS-1:0]        out_valid,
    output logic [N_PORTS-1:0]        out_err
);

    localparam int STAGE_W = N_PORTS * DATA_W + 2 * N_PORTS;

    logic [N_PORTS*DATA_W-1:0] sw_data;
    logic [N_PORTS-1:0]        sw_valid;
    logic [N_PORTS-1:0]        sw_err;

    generate
        for (genvar k = 0; k < N_PORTS; k++) begin : g_out
            logic [N_PORTS-1:0] en_k;

            xbar_sel_decode #(
                .N_PORTS (N_PORTS),
                .SEL_FMT (SEL_FMT),
                .SEL_W   (SEL_W)
            ) u_dec (
                .clk   (clk),
                .rst_n (rst_n),
                .sel   (out_sel[k*SEL_W +: SEL_W]),
                .en    (en_k),
                .err   (sw_err[k])
            );

            xbar_andor_mux #(
                .N_PORTS (N_PORTS),
                .DATA_W  (DATA_W)
            ) u_mux (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_data   (in_data),
                .in_valid  (in_valid),
                .en        (en_k),
                .out_data  (sw_data[k*DATA_W +: DATA_W]),
                .out_valid (sw_valid[k])
            );
        end
    endgenerate

    xbar_out_stage #(
        .WIDTH   (STAGE_W),
        .OUT_REG (OUT_REG)
    ) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sw_err, sw_valid, sw_data}),
        .q     ({out_err, out_valid, out_data})
    );

endmodule

// File: tb/onehot_xbar_bench.sv
module onehot_xbar_bench;
    import onehot_xbar_pkg::*;

    logic clk = 1'b0;
    logic rst_n;
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    always #2 clk = ~clk;

    // one-hot, 4 ports, combinational
    logic [31:0] a_data;
    logic [3:0]  a_valid;
    logic [15:0] a_sel;
    logic [31:0] a_out_data;
    logic [3:0]  a_out_valid;
    logic [3:0]  a_out_err;

    onehot_xbar #(
        .N_PORTS (4),
        .DATA_W  (8),
        .SEL_FMT (SEL_ONEHOT),
        .OUT_REG (1'b0)
    ) u_onehot_xbar (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (a_data),
        .in_valid  (a_valid),
        .out_sel   (a_sel),
        .out_data  (a_out_data),
        .out_valid (a_out_valid),
        .out_err   (a_out_err)
    );

    // binary, 5 ports, registered
    logic [39:0] b_data;
    logic [4:0]  b_valid;
    logic [14:0] b_sel;
    logic [39:0] b_out_data;
    logic [4:0]  b_out_valid;
    logic [4:0]  b_out_err;

    onehot_xbar #(
        .N_PORTS (5),
        .DATA_W  (8),
        .SEL_FMT (SEL_BINARY),
        .OUT_REG (1'b1)
    ) u_onehot_xbar_bin (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (b_data),
        .in_valid  (b_valid),
        .out_sel   (b_sel),
        .out_data  (b_out_data),
        .out_valid (b_out_valid),
        .out_err   (b_out_err)
    );

    // {sel, in_valid, exp_data, exp_valid, exp_err}; inputs are 11,22,33,44
    localparam logic [59:0] VEC [7] = '{
        {16'h8421, 4'hF, 32'h44332211, 4'hF, 4'h0},
        {16'h1248, 4'hF, 32'h11223344, 4'hF, 4'h0},
        {16'h4444, 4'hF, 32'h33333333, 4'hF, 4'h0},
        {16'h0000, 4'hF, 32'h00000000, 4'h0, 4'h0},
        {16'h10C3, 4'hF, 32'h11007733, 4'hB, 4'h3},
        {16'h8421, 4'h5, 32'h44332211, 4'h5, 4'h0},
        {16'h4186, 4'h2, 32'h33114433, 4'h1, 4'h1}
    };

    function automatic string tag_of(input int k);
        case (k)
            0:       return "R1 R9 identity";
            1:       return "R10 reverse permutation";
            2:       return "R6 multicast";
            3:       return "R2 empty select";
            4:       return "R3 multi-bit select";
            5:       return "R7 valid with data";
            default: return "R7 R3 mixed valid";
        endcase
    endfunction

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        a_data  = 32'h44332211;
        a_valid = 4'h0;
        a_sel   = 16'h0;
        b_data  = 40'hA4A3A2A1A0;
        b_valid = 5'h1F;
        b_sel   = {3'd1, 3'd0, 3'd4, 3'd3, 3'd2};
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset data",  64'(b_out_data),  64'h0);
        chk("R8 reset valid", 64'(b_out_valid), 64'h0);
        chk("R8 reset err",   64'(b_out_err),   64'h0);
        rst_n = 1'b1;

        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            a_sel   = VEC[k][59:44];
            a_valid = VEC[k][43:40];
            #1;
            chk({tag_of(k), " data"},  64'(a_out_data),  64'(VEC[k][39:8]));
            chk({tag_of(k), " valid"}, 64'(a_out_valid), 64'(VEC[k][7:4]));
            chk({tag_of(k), " err"},   64'(a_out_err),   64'(VEC[k][3:0]));
        end

        // route pattern loaded during the loop above
        chk("R4 R10 binary route data", 64'(b_out_data), 64'hA1A0A4A3A2);
        chk("R4 binary route err",      64'(b_out_err),  64'h0);

        @(negedge clk);
        b_sel = {3'd4, 3'd0, 3'd6, 3'd7, 3'd5};
        #1;
        chk("R8 output held before edge", 64'(b_out_data), 64'hA1A0A4A3A2);
        @(negedge clk);
        chk("R5 out of range data",  64'(b_out_data),  64'hA4A0000000);
        chk("R5 out of range valid", 64'(b_out_valid), 64'h18);
        chk("R5 out of range err",   64'(b_out_err),   64'h07);

        b_sel   = {5{3'd3}};
        b_valid = 5'b10111;
        @(negedge clk);
        chk("R6 binary multicast data",  64'(b_out_data),  64'hA3A3A3A3A3);
        chk("R7 binary multicast valid", 64'(b_out_valid), 64'h00);

        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 mid-run reset data",  64'(b_out_data),  64'h0);
        chk("R8 mid-run reset valid", 64'(b_out_valid), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 after reset release", 64'(b_out_data), 64'hA3A3A3A3A3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule